// File: doc/BRIEF.md
# Adaptive Residue Nonlinearity Corrector

This block sits behind one stage of a pipelined analog-to-digital converter whose interstage amplifier runs open loop. Such an amplifier compresses large signals, so the residue it hands to the back end follows a cubic curve rather than a straight line. The block takes each signed raw residue code and subtracts an error term. That term is a fixed cubic shape of the raw code, scaled by one signed correction coefficient. The result is a linearized code, produced two clocks after the raw code arrives.

The coefficient is trimmed in the background while conversion goes on, with no idle calibration window. Two distance estimates come from the two conversion segments of the stage. Each time a new estimate pair is flagged valid, their difference (high segment minus low segment) is scaled by a power-of-two step and added into a saturating accumulator. The upper bits of that accumulator are the coefficient. Over many updates the loop pushes the mean of the estimate difference toward zero. The cubic shape is computed by multiplication, so the block needs no stored table contents.

Top module: `residue_linearizer`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `outValid` is 0, `outCode` is 0 and `coefOut` is 0.
- R2: A raw code presented with `rawValid` high at rising edge k appears at `outCode` after edge k+1, and `outValid` is high for exactly that cycle. A cycle with `rawValid` low gives a cycle with `outValid` low two edges later.
- R3: With coefficient p (signed 16-bit, 15 fraction bits) and raw code D (signed 12-bit), the output is D − floor(p·c / 2^15), where c = floor(D³ / 2^22). Both shifts are arithmetic and round toward minus infinity.
- R4: The corrected result is clamped to the signed 12-bit range [−2048, 2047] instead of wrapping.
- R5: `outCode` keeps its last value in every cycle in which `outValid` is low.
- R6: With coefficient 0, the output equals the raw code for every raw code.
- R7: On each rising edge with `estValid` high, the 24-bit accumulator gains floor(((distHi − distLo)·2^8) / 2^stepShift). The distances are unsigned 12-bit values, and `coefOut` is the top 16 bits of the accumulator.
- R8: While `estValid` is low, `distHi`, `distLo` and `stepShift` have no effect on `coefOut`.
- R9: The accumulator saturates at −2^23 and 2^23 − 1. Repeated updates in one direction therefore pin `coefOut` at −32768 or 32767 and never wrap.
- R10: Every `stepShift` value from 0 to 15 divides the scaled estimate difference by the matching power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rawValid | input | 1 | Raw residue code is valid this cycle |
| rawCode | input | 12 | Raw residue code, two's complement |
| estValid | input | 1 | New distance-estimate pair is valid this cycle |
| distHi | input | 12 | Distance estimate of the upper segment, unsigned |
| distLo | input | 12 | Distance estimate of the lower segment, unsigned |
| stepShift | input | 4 | Adaptation step exponent; the step is 2^-stepShift |
| outValid | output | 1 | Corrected code is valid |
| outCode | output | 12 | Corrected residue code, two's complement |
| coefOut | output | 16 | Current correction coefficient, signed, 15 fraction bits |

## Verification
The bench sweeps every raw code, including both extreme codes and code 0, at several coefficient values, including the pinned extremes −32768 and 32767. A design that wrapped instead of clamping would show a large negative output near the positive full-scale code once the coefficient is at −1. A design that truncated negative cubes toward zero would be off by one on many negative codes. Some sweeps drop the valid strobe at intervals. This exposes an output that moves on invalid cycles or a valid flag that is one cycle early or late. The adaptation tests drive the accumulator into both limits and walk through all sixteen step sizes with differences of both signs. They also apply large differences with the estimate strobe low, which catches wrap-around, rounding of negative steps toward zero, and updates that ignore the strobe.

// File: rtl/residue_linearizer_pkg.sv
package residue_linearizer_pkg;

  // strobes the control half issues to the datapath each cycle
  typedef struct packed {
    logic captureEn;  // load the first pipeline register
    logic emitEn;     // load the output register
    logic adaptEn;    // apply one coefficient update
  } ctrlStrobes_t;

endpackage

// File: rtl/residue_lin_ctrl.sv
module residue_lin_ctrl
  import residue_linearizer_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         rawValid,
  input  logic         estValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= rawValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.captureEn = rawValid;
    strobes.emitEn    = stage1Valid;
    strobes.adaptEn   = estValid;
  end

  // R2: a valid raw code must reach the output two edges later
  assert_valid_two_R2: assert property (@(posedge clk) disable iff (rst)
    rawValid |=> ##1 outValid);
  assert_invalid_two_R2: assert property (@(posedge clk) disable iff (rst)
    !rawValid |=> ##1 !outValid);

endmodule

// File: rtl/residue_lin_coef.sv
module residue_lin_coef
  import residue_linearizer_pkg::*;
#(
  parameter int EST_W   = 12,
  parameter int ACC_W   = 24,
  parameter int COEF_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobes_t             strobes,
  input  logic [EST_W-1:0]         distHi,
  input  logic [EST_W-1:0]         distLo,
  input  logic [SHIFT_W-1:0]       stepShift,
  output logic signed [COEF_W-1:0] coef
);

  localparam int DIFF_W   = EST_W + 1;
  localparam int UP_SHIFT = ACC_W - COEF_W;
  localparam int SUM_W    = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] ACC_MAX = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] ACC_MIN = -(SUM_W'(64'sd1 <<< (ACC_W - 1)));

  logic signed [ACC_W-1:0]  acc;
  logic signed [DIFF_W-1:0] diff;
  logic signed [SUM_W-1:0]  incr;
  logic signed [SUM_W-1:0]  accSum;
  logic signed [ACC_W-1:0]  accNext;

  always_comb begin
    diff   = $signed({1'b0, distHi}) - $signed({1'b0, distLo});
    incr   = (SUM_W'(diff) <<< UP_SHIFT) >>> stepShift;
    accSum = SUM_W'(acc) + incr;
    if (accSum > ACC_MAX)      accNext = ACC_W'(ACC_MAX);
    else if (accSum < ACC_MIN) accNext = ACC_W'(ACC_MIN);
    else                       accNext = ACC_W'(accSum);
  end

  always_ff @(posedge clk) begin
    if (rst)                  acc <= '0;
    else if (strobes.adaptEn) acc <= accNext;
  end

  assign coef = acc[ACC_W-1 -: COEF_W];

  // R8: no estimate strobe, no movement of the accumulator
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.adaptEn |=> $stable(acc));
  // R9: a non-negative step never lowers the accumulator (no wrap at the top)
  assert_no_wrap_up_R9: assert property (@(posedge clk) disable iff (rst)
    (strobes.adaptEn && incr >= 0) |=> acc >= $past(acc));
  // R9: a negative step never raises the accumulator (no wrap at the bottom)
  assert_no_wrap_down_R9: assert property (@(posedge clk) disable iff (rst)
    (strobes.adaptEn && incr < 0) |=> acc <= $past(acc));

endmodule

// File: rtl/residue_lin_path.sv
module residue_lin_path
  import residue_linearizer_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobes_t             strobes,
  input  logic signed [RAW_W-1:0]  rawCode,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [RAW_W-1:0]  outCode
);

  localparam int FULL_W     = 3 * RAW_W;
  localparam int CUBE_SHIFT = 2 * (RAW_W - 1);
  localparam int CUBE_W     = RAW_W + 1;
  localparam int PROD_W     = COEF_W + CUBE_W;
  localparam int FRAC       = COEF_W - 1;
  localparam int ERR_W      = PROD_W - FRAC;
  localparam int SUM_W      = (ERR_W > RAW_W ? ERR_W : RAW_W) + 1;
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((64'sd1 <<< (RAW_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = -(SUM_W'(64'sd1 <<< (RAW_W - 1)));

  logic signed [RAW_W-1:0]  rawQ;
  logic signed [CUBE_W-1:0] cubeQ;
  logic signed [FULL_W-1:0] rawExt;
  logic signed [FULL_W-1:0] cubeFull;
  logic signed [CUBE_W-1:0] cubeNext;
  logic signed [PROD_W-1:0] prod;
  logic signed [ERR_W-1:0]  errTerm;
  logic signed [SUM_W-1:0]  corrSum;
  logic signed [RAW_W-1:0]  corrSat;

  // stage 1: normalized cube of the raw code (|c| <= 2^(RAW_W-1))
  always_comb begin
    rawExt   = FULL_W'(rawCode);
    cubeFull = rawExt * rawExt * rawExt;
    cubeNext = CUBE_W'(cubeFull >>> CUBE_SHIFT);
  end

  // stage 2: scale by the coefficient, subtract, clamp
  always_comb begin
    prod    = PROD_W'(coef) * PROD_W'(cubeQ);
    errTerm = ERR_W'(prod >>> FRAC);
    corrSum = SUM_W'(rawQ) - SUM_W'(errTerm);
    if (corrSum > OUT_MAX)      corrSat = RAW_W'(OUT_MAX);
    else if (corrSum < OUT_MIN) corrSat = RAW_W'(OUT_MIN);
    else                        corrSat = RAW_W'(corrSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawQ    <= '0;
      cubeQ   <= '0;
      outCode <= '0;
    end else begin
      if (strobes.captureEn) begin
        rawQ  <= rawCode;
        cubeQ <= cubeNext;
      end
      if (strobes.emitEn) outCode <= corrSat;
    end
  end

  // R5: the output register moves only when a result is emitted
  assert_hold_out_R5: assert property (@(posedge clk) disable iff (rst)
    !strobes.emitEn |=> $stable(outCode));
  // R6: a zero coefficient passes the captured raw code straight through
  assert_zero_coef_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.emitEn && coef == '0) |=> outCode == $past(rawQ));

endmodule

// File: rtl/residue_linearizer.sv
module residue_linearizer
  import residue_linearizer_pkg::*;
#(
  parameter int RAW_W   = 12,
  parameter int EST_W   = 12,
  parameter int ACC_W   = 24,
  parameter int COEF_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rawValid,
  input  logic signed [RAW_W-1:0]  rawCode,
  input  logic                     estValid,
  input  logic [EST_W-1:0]         distHi,
  input  logic [EST_W-1:0]         distLo,
  input  logic [SHIFT_W-1:0]       stepShift,
  output logic                     outValid,
  output logic signed [RAW_W-1:0]  outCode,
  output logic signed [COEF_W-1:0] coefOut
);

  ctrlStrobes_t strobes;

  residue_lin_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rawValid (rawValid),
    .estValid (estValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  residue_lin_coef #(
    .EST_W   (EST_W),
    .ACC_W   (ACC_W),
    .COEF_W  (COEF_W),
    .SHIFT_W (SHIFT_W)
  ) u_coef (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .distHi    (distHi),
    .distLo    (distLo),
    .stepShift (stepShift),
    .coef      (coefOut)
  );

  residue_lin_path #(
    .RAW_W  (RAW_W),
    .COEF_W (COEF_W)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rawCode (rawCode),
    .coef    (coefOut),
    .outCode (outCode)
  );

endmodule

// File: tb/residue_linearizer_test.sv
`timescale 1ns/1ps
module residue_linearizer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawValid = 1'b0;
  logic signed [11:0] rawCode = '0;
  logic estValid = 1'b0;
  logic [11:0] distHi = '0;
  logic [11:0] distLo = '0;
  logic [3:0] stepShift = '0;
  logic outValid;
  logic signed [11:0] outCode;
  logic signed [15:0] coefOut;

  int checks = 0;
  int fails = 0;
  longint accModel = 0;
  longint outModel = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  residue_linearizer uut (
    .clk(clk), .rst(rst), .rawValid(rawValid), .rawCode(rawCode),
    .estValid(estValid), .distHi(distHi), .distLo(distLo),
    .stepShift(stepShift), .outValid(outValid), .outCode(outCode),
    .coefOut(coefOut)
  );

  function automatic longint corrModel(longint d, longint p);
    longint c, e, y;
    c = (d * d * d) >>> 22;
    e = (p * c) >>> 15;
    y = d - e;
    if (y > 2047) y = 2047;
    if (y < -2048) y = -2048;
    return y;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; rawValid = 1'b0; estValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    accModel = 0;
    outModel = 0;
    check("R1 outValid", longint'(outValid), 0);
    check("R1 outCode", longint'(outCode), 0);
    check("R1 coefOut", longint'(coefOut), 0);
  endtask

  // one coefficient update; checks coefOut one edge later
  task automatic adapt(int hi, int lo, int sh, bit en, string req);
    longint inc;
    @(negedge clk);
    distHi = 12'(hi); distLo = 12'(lo); stepShift = 4'(sh); estValid = en;
    @(negedge clk);
    estValid = 1'b0;
    if (en) begin
      inc = (longint'(hi - lo) * 256) >>> sh;
      accModel += inc;
      if (accModel > 8388607) accModel = 8388607;
      if (accModel < -8388608) accModel = -8388608;
    end
    check(req, longint'(coefOut), accModel >>> 8);
  endtask

  // stream every raw code; gapEvery > 0 drops rawValid periodically
  task automatic sweep(int gapEvery, string req);
    bit vh [0:4097];
    longint ch [0:4097];
    longint p;
    p = accModel >>> 8;
    for (int j = 0; j < 4098; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check({"R2 outValid ", req}, longint'(outValid), longint'(vh[j-2]));
        if (vh[j-2]) outModel = corrModel(ch[j-2], p);
        check({"R3/R4/R5 outCode ", req}, longint'(outCode), outModel);
      end else begin
        check("R2 outValid idle", longint'(outValid), 0);
      end
      if (j < 4096) begin
        vh[j] = (gapEvery == 0) || (j % gapEvery != 0);
        ch[j] = longint'(j - 2048);
        rawValid = vh[j];
        rawCode = 12'(j - 2048);
      end else begin
        vh[j] = 1'b0;
        rawValid = 1'b0;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();                                   // R1
    sweep(0, "R6 coef0");                        // R6, R3, R2
    sweep(7, "R5 gaps coef0");                   // R5
    for (int k = 0; k < 10; k++) adapt(0, 4095, 0, 1'b1, "R9 down");
    check("R9 pinned low", longint'(coefOut), -32768);
    adapt(4095, 0, 0, 1'b0, "R8 idle up");
    adapt(0, 4095, 3, 1'b0, "R8 idle down");
    sweep(0, "R4 coef-1");                       // R4 clamp at +full scale
    for (int k = 0; k < 20; k++) adapt(4095, 0, 0, 1'b1, "R9 up");
    check("R9 pinned high", longint'(coefOut), 32767);
    sweep(5, "R3 coef+1");
    doReset();                                   // R1 again
    adapt(0, 4095, 0, 1'b1, "R7 step");
    adapt(0, 4095, 0, 1'b1, "R7 step");
    adapt(0, 2, 0, 1'b1, "R7 step");
    check("R7 coef -8192", longint'(coefOut), -8192);
    sweep(0, "R3 coef-0.25");
    for (int s = 0; s < 16; s++) begin
      adapt(160 + s * 37, 0, s, 1'b1, "R10 pos shift");
      adapt(0, 100 + s * 53, s, 1'b1, "R10 neg shift");
    end
    adapt(1234, 1234, 0, 1'b1, "R7 zero diff");
    sweep(3, "R3 coef mixed");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule